// File: doc/BRIEF.md
# Infrared Transceiver Mode and Drive Controller

This block is the digital control core of an infrared transceiver whose emitter path is shared by serial IrDA data and remote-control transmission. It samples three active-high pins: a shutdown request, an IrDA transmit line and a remote-control transmit line. It brings them into its reference clock domain and turns them into the enables for the IR emitter and the remote-control emitter. It also produces the receiver bandwidth select and the receive-output enable, which acts as the tri-state control.

Mode is programmed over the same pins that carry data. A short high pulse on the shutdown pin opens a programming window. When the pin falls, the state of the IrDA transmit line decides the result:

- The line is held high and stable at the fall: the wide bandwidth is selected.
- The line was never high in the window: the narrow bandwidth is selected.
- A complete pulse rose and fell inside the window: the IrDA line becomes the remote-control drive input (single-pin mode).

A long high level on the shutdown pin is a full shutdown instead. Pulses of an intermediate length are rejected and set a sticky error flag. A guard on each transmit input limits how long an emitter can stay lit.

All timing limits are parameters counted in reference-clock cycles. Each input passes through `SYNC_STAGES` flops, and every output is registered.

Top module: `irx_mode_ctrl`

## Requirements
- R1: After reset the mode is narrow-bandwidth IrDA. The outputs are then: `ir_led_en`=0, `rc_led_en`=0, `bw_fast`=0, `rx_oe`=1 and `prog_err`=0.
- R2: With `sd_in` low, in either IrDA mode, the transmit inputs act as follows:
  - Both inputs low leaves both emitters off with `rx_oe`=1.
  - `txrc_in` alone sets `rc_led_en`=1.
  - `txir_in` alone sets `ir_led_en`=1.
- R3: When `txir_in` and `txrc_in` are both high, both emitter enables are 0.
- R4: Holding `sd_in` high for at least `SHUT_CYC` cycles enters shutdown. In shutdown, `rx_oe`=0 and both emitter enables are 0 whatever the transmit inputs do. When `sd_in` returns low, the block leaves shutdown in narrow-bandwidth mode (`bw_fast`=0), with `rx_oe`=1 and no error raised.
- R5: An `sd_in` pulse shorter than `PROG_MAX_CYC` cycles programs the bandwidth. The mode is committed `EDGE_CYC` cycles after the fall, and the outcome depends on `txir_in` at the fall:
  - `txir_in` high, unchanged for `EDGE_CYC` cycles before and after the fall, selects the wide bandwidth (`bw_fast`=1).
  - `txir_in` never high selects the narrow bandwidth (`bw_fast`=0).
- R6: A `txir_in` pulse can select remote-control mode. The pulse must rise at least `SETUP_CYC` cycles after `sd_in` rose, stay high at least `RCPW_CYC` cycles, and fall before `sd_in` falls. In remote-control mode:
  - `txir_in` alone drives `rc_led_en`.
  - `ir_led_en` stays 0.
  - `bw_fast`=0.
- R7: An `sd_in` pulse of at least `PROG_MAX_CYC` but fewer than `SHUT_CYC` cycles leaves the mode unchanged and sets `prog_err`=1.
- R8: Either of two timing violations leaves the mode unchanged and sets `prog_err`=1:
  - `txir_in` changes within `EDGE_CYC` cycles after the `sd_in` fall.
  - `txir_in` rises fewer than `SETUP_CYC` cycles into the window.
- R9: `prog_err` stays 1 until reset, including through shutdown.
- R10: Continuous high on a transmit input keeps the matching emitter lit for exactly `MAXON_CYC` cycles. The emitter then stays off until that input goes low, and the next high level lights it again.
- R11: While `sd_in` is high, both emitter enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_in | input | 1 | Shutdown / programming pin, active high, asynchronous |
| txir_in | input | 1 | IrDA transmit data pin, active high, asynchronous |
| txrc_in | input | 1 | Remote-control transmit pin, active high, asynchronous |
| ir_led_en | output | 1 | IR emitter enable |
| rc_led_en | output | 1 | Remote-control emitter enable |
| bw_fast | output | 1 | Receiver bandwidth: 1 wide (MIR/FIR), 0 narrow (SIR) |
| rx_oe | output | 1 | Receive-output enable; 0 tri-states the receive pin |
| prog_err | output | 1 | Sticky flag for a rejected programming pulse |

## Verification
The assertions check four properties on every cycle:

- The two emitter enables are never on together.
- Both enables are off in the cycle after shutdown, after a programming-window cycle and after simultaneous transmit requests.
- Shutdown always carries the narrow-bandwidth mode.
- The error flag never clears without a reset.

Only the bench scenarios can show the pulse classification. This covers the outcome of each programming pulse, the rejection of windows that are too long or violate setup and hold, the return to narrow bandwidth after shutdown, and the exact emitter on-time under a stuck input.

// File: rtl/irx_pkg.sv
package irx_pkg;
  typedef enum logic [1:0] {
    MODE_SIR = 2'd0,
    MODE_FIR = 2'd1,
    MODE_RC  = 2'd2
  } irx_mode_e;
endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irx_on_guard.sv
module irx_on_guard #(
  parameter int MAXON_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic allow
);
  localparam int CW = $clog2(MAXON_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAXON_CYC);

  logic [CW-1:0] on_cnt;

  always_ff @(posedge clk) begin
    if (rst)               on_cnt <= '0;
    else if (!req)         on_cnt <= '0;
    else if (on_cnt < LIMIT) on_cnt <= on_cnt + 1'b1;
  end

  assign allow = (on_cnt < LIMIT);

  AST_ON_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    on_cnt <= LIMIT); // R10
  AST_ON_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !req |=> on_cnt == '0); // R10
endmodule

// File: rtl/irx_sd_ctrl.sv
module irx_sd_ctrl
  import irx_pkg::*;
#(
  parameter int SHUT_CYC     = 7500,
  parameter int PROG_MAX_CYC = 1250,
  parameter int SETUP_CYC    = 50,
  parameter int RCPW_CYC     = 50,
  parameter int EDGE_CYC     = 13
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sd_s,
  input  logic      txir_s,
  output logic      shut,
  output irx_mode_e mode,
  output logic      err
);
  localparam int SW = $clog2(SHUT_CYC + 1);
  localparam int PW = $clog2(RCPW_CYC + 1);
  localparam int EW = $clog2(EDGE_CYC + 1);
  localparam logic [SW-1:0] SHUT_LIM  = SW'(SHUT_CYC);
  localparam logic [SW-1:0] SHUT_LAST = SW'(SHUT_CYC - 1);
  localparam logic [SW-1:0] PROG_LIM  = SW'(PROG_MAX_CYC);
  localparam logic [SW-1:0] SETUP_LIM = SW'(SETUP_CYC);
  localparam logic [PW-1:0] RCPW_LIM  = PW'(RCPW_CYC);
  localparam logic [EW-1:0] EDGE_LIM  = EW'(EDGE_CYC);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_CYC - 1);

  logic          sd_d, ir_d;
  logic [SW-1:0] sd_cnt;
  logic [PW-1:0] ir_hi_cnt;
  logic [EW-1:0] quiet_cnt, hold_cnt;
  logic          rose_in_win, rc_seen, setup_bad;
  logic          hold_act;
  irx_mode_e     cand;

  logic sd_rise, sd_fall, ir_rise, ir_fall, ir_chg, in_win;
  assign sd_rise = sd_s & ~sd_d;
  assign sd_fall = ~sd_s & sd_d;
  assign ir_rise = txir_s & ~ir_d;
  assign ir_fall = ~txir_s & ir_d;
  assign ir_chg  = txir_s ^ ir_d;
  assign in_win  = sd_s & ~shut;

  // edge history and TXIR quiet time
  always_ff @(posedge clk) begin
    if (rst) begin
      sd_d      <= 1'b0;
      ir_d      <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      sd_d <= sd_s;
      ir_d <= txir_s;
      if (ir_chg)                    quiet_cnt <= '0;
      else if (quiet_cnt < EDGE_LIM) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // SD high-time counter
  always_ff @(posedge clk) begin
    if (rst)                        sd_cnt <= '0;
    else if (!sd_s)                 sd_cnt <= '0;
    else if (sd_cnt < SHUT_LIM)     sd_cnt <= sd_cnt + 1'b1;
  end

  // TXIR pulse tracking inside the programming window
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_hi_cnt   <= '0;
      rose_in_win <= 1'b0;
      rc_seen     <= 1'b0;
      setup_bad   <= 1'b0;
    end else begin
      if (!txir_s)                   ir_hi_cnt <= '0;
      else if (ir_hi_cnt < RCPW_LIM) ir_hi_cnt <= ir_hi_cnt + 1'b1;
      if (sd_rise) begin
        rose_in_win <= 1'b0;
        rc_seen     <= 1'b0;
        setup_bad   <= 1'b0;
      end
      if (in_win && ir_rise) begin
        if (sd_cnt < SETUP_LIM) setup_bad   <= 1'b1;
        else                    rose_in_win <= 1'b1;
      end
      if (in_win && ir_fall) begin
        rose_in_win <= 1'b0;
        if (rose_in_win && ir_hi_cnt >= RCPW_LIM) rc_seen <= 1'b1;
      end
    end
  end

  // shutdown, classification, deferred commit
  always_ff @(posedge clk) begin
    if (rst) begin
      shut     <= 1'b0;
      mode     <= MODE_SIR;
      err      <= 1'b0;
      hold_act <= 1'b0;
      hold_cnt <= '0;
      cand     <= MODE_SIR;
    end else begin
      if (hold_act) begin
        if (ir_chg || sd_s) begin
          err      <= 1'b1;
          hold_act <= 1'b0;
        end else if (hold_cnt == EDGE_LAST) begin
          mode     <= cand;
          hold_act <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
      if (sd_s && !shut && sd_cnt == SHUT_LAST) begin
        shut     <= 1'b1;
        mode     <= MODE_SIR;
        hold_act <= 1'b0;
      end
      if (sd_fall) begin
        if (shut) begin
          shut <= 1'b0;
          mode <= MODE_SIR;
        end else if (sd_cnt >= PROG_LIM) begin
          err <= 1'b1;
        end else if (setup_bad || ir_chg || quiet_cnt < EDGE_LIM) begin
          err <= 1'b1;
        end else begin
          hold_act <= 1'b1;
          hold_cnt <= '0;
          if (rc_seen)     cand <= MODE_RC;
          else if (txir_s) cand <= MODE_FIR;
          else             cand <= MODE_SIR;
        end
      end
    end
  end

  AST_SHUT_IS_SIR: assert property (@(posedge clk) disable iff (rst)
    shut |-> mode == MODE_SIR); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3); // R5
endmodule

// File: rtl/irx_mode_ctrl.sv
module irx_mode_ctrl
  import irx_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SHUT_CYC     = 7500,
  parameter int PROG_MAX_CYC = 1250,
  parameter int SETUP_CYC    = 50,
  parameter int RCPW_CYC     = 50,
  parameter int EDGE_CYC     = 13,
  parameter int MAXON_CYC    = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic sd_in,
  input  logic txir_in,
  input  logic txrc_in,
  output logic ir_led_en,
  output logic rc_led_en,
  output logic bw_fast,
  output logic rx_oe,
  output logic prog_err
);
  localparam int NPIN = 3;
  localparam int NTX  = 2;

  logic [NPIN-1:0] pins_s;
  logic sd_s, txir_s, txrc_s;

  irx_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({txrc_in, txir_in, sd_in}),
    .dout(pins_s)
  );
  assign sd_s   = pins_s[0];
  assign txir_s = pins_s[1];
  assign txrc_s = pins_s[2];

  logic      shut, err;
  irx_mode_e mode;

  irx_sd_ctrl #(
    .SHUT_CYC    (SHUT_CYC),
    .PROG_MAX_CYC(PROG_MAX_CYC),
    .SETUP_CYC   (SETUP_CYC),
    .RCPW_CYC    (RCPW_CYC),
    .EDGE_CYC    (EDGE_CYC)
  ) i_sd_ctrl (
    .clk   (clk),
    .rst   (rst),
    .sd_s  (sd_s),
    .txir_s(txir_s),
    .shut  (shut),
    .mode  (mode),
    .err   (err)
  );

  logic [NTX-1:0] tx_req, tx_ok;
  assign tx_req = {txrc_s, txir_s};

  genvar g;
  generate
    for (g = 0; g < NTX; g++) begin : g_guard
      irx_on_guard #(.MAXON_CYC(MAXON_CYC)) i_guard (
        .clk  (clk),
        .rst  (rst),
        .req  (tx_req[g]),
        .allow(tx_ok[g])
      );
    end
  endgenerate

  logic busy, ir_only, rc_only, single_rc;
  logic ir_nxt, rc_nxt;
  always_comb begin
    busy      = sd_s | shut;
    ir_only   = txir_s & ~txrc_s;
    rc_only   = txrc_s & ~txir_s;
    single_rc = (mode == MODE_RC);
    ir_nxt    = ~busy & ir_only & ~single_rc & tx_ok[0];
    rc_nxt    = ~busy & ((rc_only & tx_ok[1]) | (ir_only & single_rc & tx_ok[0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_led_en <= 1'b0;
      rc_led_en <= 1'b0;
      bw_fast   <= 1'b0;
      rx_oe     <= 1'b1;
    end else begin
      ir_led_en <= ir_nxt;
      rc_led_en <= rc_nxt;
      bw_fast   <= (mode == MODE_FIR);
      rx_oe     <= ~shut;
    end
  end
  assign prog_err = err;

  AST_LED_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ir_led_en && rc_led_en)); // R2
  AST_BOTH_TX_DARK: assert property (@(posedge clk) disable iff (rst)
    (txir_s && txrc_s) |=> !ir_led_en && !rc_led_en); // R3
  AST_SHUT_DARK: assert property (@(posedge clk) disable iff (rst)
    shut |=> !rx_oe && !ir_led_en && !rc_led_en); // R4
  AST_SD_HIGH_DARK: assert property (@(posedge clk) disable iff (rst)
    sd_s |=> !ir_led_en && !rc_led_en); // R11
endmodule

// File: tb/test_irx_mode_ctrl.sv
module test_irx_mode_ctrl;
  localparam int SHUT  = 300;
  localparam int PMAX  = 60;
  localparam int MAXON = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd = 1'b0, txir = 1'b0, txrc = 1'b0;
  logic ir_led, rc_led, bw, oe, perr;

  always #2 clk = ~clk;

  irx_mode_ctrl #(
    .SYNC_STAGES(2), .SHUT_CYC(SHUT), .PROG_MAX_CYC(PMAX),
    .SETUP_CYC(5), .RCPW_CYC(5), .EDGE_CYC(3), .MAXON_CYC(MAXON)
  ) i_irx_mode_ctrl (
    .clk(clk), .rst(rst), .sd_in(sd), .txir_in(txir), .txrc_in(txrc),
    .ir_led_en(ir_led), .rc_led_en(rc_led), .bw_fast(bw), .rx_oe(oe),
    .prog_err(perr)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    sd = 0; txir = 0; txrc = 0; rst = 1;
    tick(4);
    rst = 0;
    tick(4);
  endtask

  task automatic prog_fir();
    txir = 1; tick(10);
    sd = 1; tick(20); sd = 0;
    tick(10); txir = 0; tick(10);
  endtask

  // {txir, txrc, exp_ir, exp_rc, exp_oe}, SD low, narrow mode
  localparam int NV = 6;
  localparam logic [4:0] VEC [NV] = '{
    5'b00_001, 5'b01_011, 5'b10_101, 5'b11_001, 5'b00_001, 5'b10_101
  };

  initial begin
    tick(150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 ir_led", ir_led, 0);
    check("R1 rc_led", rc_led, 0);
    check("R1 bw", bw, 0);
    check("R1 rx_oe", oe, 1);
    check("R1 err", perr, 0);

    // R2 / R3 truth table vectors
    for (int i = 0; i < NV; i++) begin
      txir = VEC[i][4]; txrc = VEC[i][3];
      tick(6);
      check(VEC[i][4] & VEC[i][3] ? "R3 ir_led" : "R2 ir_led", ir_led, VEC[i][2]);
      check(VEC[i][4] & VEC[i][3] ? "R3 rc_led" : "R2 rc_led", rc_led, VEC[i][1]);
      check("R2 rx_oe", oe, VEC[i][0]);
    end
    txir = 0; txrc = 0; tick(6);

    // R5 wide bandwidth
    prog_fir();
    check("R5 bw wide", bw, 1);
    check("R5 no err", perr, 0);
    txir = 1; tick(6);
    check("R2 ir_led in wide mode", ir_led, 1);
    txir = 0; tick(6);

    // R11 emitters dark while SD high, then SD fall with TXIR low selects narrow
    txrc = 1; tick(6);
    check("R11 rc before", rc_led, 1);
    sd = 1; tick(10);
    check("R11 rc dark", rc_led, 0);
    tick(10); sd = 0; tick(10);
    check("R11 rc back", rc_led, 1);
    check("R5 bw narrow", bw, 0);
    txrc = 0; tick(6);

    // R6 remote-control single-pin mode
    sd = 1; tick(10); txir = 1; tick(10); txir = 0; tick(10); sd = 0; tick(10);
    check("R6 bw", bw, 0);
    check("R6 no err", perr, 0);
    txir = 1; tick(6);
    check("R6 rc_led", rc_led, 1);
    check("R6 ir_led", ir_led, 0);
    txir = 0; tick(6);
    check("R6 rc_led off", rc_led, 0);

    // R4 shutdown, then return to narrow mode
    prog_fir();
    check("R4 pre bw", bw, 1);
    sd = 1; tick(SHUT + 20);
    check("R4 rx_oe", oe, 0);
    txrc = 1; tick(6);
    check("R4 rc dark", rc_led, 0);
    check("R4 ir dark", ir_led, 0);
    txrc = 0; tick(4);
    sd = 0; tick(10);
    check("R4 rx_oe back", oe, 1);
    check("R4 bw narrow", bw, 0);
    check("R4 no err", perr, 0);

    // R7 invalid length pulse
    prog_fir();
    sd = 1; tick(150); sd = 0; tick(10);
    check("R7 err", perr, 1);
    check("R7 bw kept", bw, 1);
    check("R7 rx_oe", oe, 1);
    // R9 sticky through shutdown
    sd = 1; tick(SHUT + 20); sd = 0; tick(10);
    check("R9 err sticky", perr, 1);

    // R8 hold violation
    do_reset();
    txir = 1; tick(10);
    sd = 1; tick(20); sd = 0; tick(1); txir = 0; tick(10);
    check("R8 hold err", perr, 1);
    check("R8 hold bw kept", bw, 0);

    // R8 setup violation: early TXIR pulse does not select RC
    do_reset();
    sd = 1; tick(2); txir = 1; tick(10); txir = 0; tick(10); sd = 0; tick(10);
    check("R8 setup err", perr, 1);
    txir = 1; tick(6);
    check("R8 setup ir_led", ir_led, 1);
    check("R8 setup rc_led", rc_led, 0);
    txir = 0; tick(6);

    // R10 stuck IR input
    do_reset();
    begin
      int on = 0;
      txir = 1;
      for (int k = 0; k < MAXON + 200; k++) begin
        tick(1);
        if (ir_led) on++;
      end
      check("R10 ir on-time", on, MAXON);
      check("R10 ir held off", ir_led, 0);
      txir = 0; tick(6); txir = 1; tick(6);
      check("R10 ir rearm", ir_led, 1);
      txir = 0; tick(6);
    end
    // R10 stuck RC input
    begin
      int on = 0;
      txrc = 1;
      for (int k = 0; k < MAXON + 200; k++) begin
        tick(1);
        if (rc_led) on++;
      end
      check("R10 rc on-time", on, MAXON);
      txrc = 0; tick(6);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule